// File: doc/BRIEF.md
# Wait and Stop Power-Mode Controller

This block decides when the clocks of a small 8-bit microcontroller may be switched off. The CPU hands it one-cycle strobes for its two low-power opcodes, together with the interrupt mask bits, the stop-disable bit of its condition codes, the watchdog-off configuration and the enable bits of the serial peripherals. In return the block drives one clock enable each for the CPU, the free-running timer, the SPI, the SCI transmitter, the SCI receiver and the oscillator.

A wait request first lets the CPU finish pushing its registers. When the CPU reports that stacking is done, the CPU clock is dropped. While it waits, the block asks the bus for repeated reads of the address at which the condition-code byte was stored. A stop request halts everything, including the oscillator, unless stop is disabled, in which case the opcode does nothing. The external interrupt, non-maskable interrupt and reset pins are brought in through two-flop synchronizers to decide when to wake. In stop, the raw pin levels turn the oscillator back on without waiting for a clock. A reset-pin wake is passed on as a one-cycle routing pulse. An interrupt wake waits a fixed settling time before the CPU clock returns.

Top module: `pm_power_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mode is run (code 0), every clock enable is 1, `bus_rd_req` is 0 and `rst_route` is 0.
- R2: In run mode, `wait_op` moves the block to the stacking mode (code 1), where every clock stays on. `stack_done` in the stacking mode moves it to wait (code 2) on the next edge, where `cpu_clk_en` is 0 and `osc_en` is 1. `wait_op` wins over `stop_op` when both arrive in the same cycle.
- R3: In wait mode `bus_rd_req` is 1 and `bus_rd_addr` holds the `stack_addr` value sampled with `stack_done`. In every other mode `bus_rd_req` is 0.
- R4: Wait is left for run on the first edge where a qualified wake is seen. A qualified wake is either a low synchronized `ext_int_n` or any `int_req` bit while `mask_int` is 0, or a low synchronized `ext_nmi_n` while `mask_nmi` is 0. Each pin passes two synchronizer flops first.
- R5: In wait, `tmr_clk_en` is 0 only when `mask_int` and `wdog_off` are both 1. Otherwise it is 1.
- R6: In wait, `spi_clk_en`, `sci_tx_clk_en` and `sci_rx_clk_en` follow `spi_on`, `sci_tx_on` and `sci_rx_on` respectively.
- R7: `stop_op` in run mode enters stop (code 3) when `stop_dis` is 0. When `stop_dis` is 1, the mode stays run and all clocks stay on.
- R8: In stop, every clock enable except the oscillator is 0. `osc_en` is the combinational OR of a low raw `ext_int_n`, `ext_nmi_n` or `ext_rst_n`, or a high `ext_int_pend`.
- R9: In stop, a low synchronized `ext_rst_n` returns the block to run and pulses `rst_route` for exactly the first run cycle. This takes precedence over an interrupt wake in the same cycle.
- R10: In stop, a low synchronized `ext_int_n` or `ext_nmi_n`, or a high `ext_int_pend`, enters recovery (code 4). Recovery lasts exactly `SETTLE_CYC` cycles with `osc_en` 1 and every other enable 0, and then the block returns to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_op | input | 1 | Wait opcode strobe |
| stop_op | input | 1 | Stop opcode strobe |
| stack_done | input | 1 | CPU has finished stacking registers |
| stack_addr | input | ADDR_W | Address of the stacked condition-code byte |
| mask_int | input | 1 | Maskable-interrupt mask bit |
| mask_nmi | input | 1 | Non-maskable-interrupt mask bit |
| stop_dis | input | 1 | Stop-disable bit; 1 turns stop into a no-operation |
| wdog_off | input | 1 | Watchdog disabled by configuration |
| spi_on | input | 1 | SPI enable bit |
| sci_tx_on | input | 1 | SCI transmitter enable bit |
| sci_rx_on | input | 1 | SCI receiver enable bit |
| ext_int_n | input | 1 | External maskable interrupt pin, active low |
| ext_nmi_n | input | 1 | External non-maskable interrupt pin, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| ext_int_pend | input | 1 | Edge-triggered external interrupt already latched |
| int_req | input | N_INT | Internal interrupt requests |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | Free-running timer clock enable |
| spi_clk_en | output | 1 | SPI clock enable |
| sci_tx_clk_en | output | 1 | SCI transmitter clock enable |
| sci_rx_clk_en | output | 1 | SCI receiver clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_rd_req | output | 1 | Request for repeated bus reads while waiting |
| bus_rd_addr | output | ADDR_W | Address for those reads |
| rst_route | output | 1 | One-cycle pulse: stop left through the reset pin |
| mode | output | 3 | Current mode: 0 run, 1 stacking, 2 wait, 3 stop, 4 recovery |

## Verification
Two wake causes can arrive in the same cycle in stop: the reset pin and the interrupt pin. The bench drops both pins at the same negative edge and requires that `rst_route` pulses, that the mode goes straight to run and that recovery never appears. The wait and stop strobes can also coincide. They are driven together with stop enabled, and the mode must become the stacking mode. A behavioural model in the bench follows the synchronizer delay with a queue and compares every output on every clock, so any wrong priority shows up in the cycle where it happens.

// File: rtl/pm_power_pkg.sv
`timescale 1ns/1ps
// Shared types for the power-mode controller.
// Assumes: mode codes are visible at the top-level port and must stay fixed.
package pm_power_pkg;

    typedef enum logic [2:0] {
        PM_RUN          = 3'd0,
        PM_WAIT_STACK   = 3'd1,
        PM_WAIT         = 3'd2,
        PM_STOP         = 3'd3,
        PM_STOP_RECOVER = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic cpu;
        logic tmr;
        logic spi;
        logic sci_tx;
        logic sci_rx;
        logic osc;
    } clk_en_t;

    localparam int PIN_W   = 3;
    localparam int PIN_INT = 0;
    localparam int PIN_NMI = 1;
    localparam int PIN_RST = 2;

endpackage

// File: rtl/pm_pin_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank for active-low external pins.
// Assumes: pins idle high, so the flops reset to 1 (inactive).
module pm_pin_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic meta_q;
            logic hold_q;

            // Shift the raw pin through two flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b1;
                    hold_q <= 1'b1;
                end else begin
                    meta_q <= pin_i[g];
                    hold_q <= meta_q;
                end
            end

            assign sync_o[g] = hold_q;
        end
    endgenerate

endmodule

// File: rtl/pm_wake_qual.sv
`timescale 1ns/1ps
// Wake qualification for wait and stop.
// Assumes: synchronized pins feed the FSM decisions; raw pins only feed the
// clockless oscillator restart used in stop.
module pm_wake_qual #(
    parameter int N_INT = 4
) (
    input  logic             s_int_n,
    input  logic             s_nmi_n,
    input  logic             s_rst_n,
    input  logic             raw_int_n,
    input  logic             raw_nmi_n,
    input  logic             raw_rst_n,
    input  logic             ext_int_pend,
    input  logic [N_INT-1:0] int_req,
    input  logic             mask_int,
    input  logic             mask_nmi,
    output logic             wait_wake,
    output logic             stop_wake_rst,
    output logic             stop_wake_int,
    output logic             stop_wake_raw
);

    logic maskable_req;

    // Collect the maskable sources and apply their masks.
    always_comb begin
        maskable_req  = !s_int_n || (|int_req);
        wait_wake     = (maskable_req && !mask_int) || (!s_nmi_n && !mask_nmi);
        stop_wake_rst = !s_rst_n;
        stop_wake_int = !s_int_n || !s_nmi_n || ext_int_pend;
        stop_wake_raw = !raw_int_n || !raw_nmi_n || !raw_rst_n || ext_int_pend;
    end

endmodule

// File: rtl/pm_clk_gate.sv
`timescale 1ns/1ps
// Per-domain clock-enable decode from the current mode.
// Assumes: enable bits are live inputs and may change during wait.
module pm_clk_gate
    import pm_power_pkg::*;
(
    input  pm_state_e state,
    input  logic      mask_int,
    input  logic      wdog_off,
    input  logic      spi_on,
    input  logic      sci_tx_on,
    input  logic      sci_rx_on,
    input  logic      stop_wake_raw,
    output clk_en_t   en
);

    // Select each enable by mode.
    always_comb begin
        en = '{cpu: 1'b1, tmr: 1'b1, spi: 1'b1, sci_tx: 1'b1, sci_rx: 1'b1, osc: 1'b1};
        case (state)
            PM_WAIT: begin
                en.cpu    = 1'b0;
                en.tmr    = !(mask_int && wdog_off);
                en.spi    = spi_on;
                en.sci_tx = sci_tx_on;
                en.sci_rx = sci_rx_on;
            end
            PM_STOP: begin
                en     = '0;
                en.osc = stop_wake_raw;
            end
            PM_STOP_RECOVER: begin
                en     = '0;
                en.osc = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pm_power_ctrl.sv
`timescale 1ns/1ps
// Power-mode controller top: mode FSM, settle counter, stacked-address hold.
// Assumes: wait_op/stop_op are single-cycle strobes from the decoder and
// stack_done is only meaningful while stacking.
module pm_power_ctrl
    import pm_power_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int N_INT      = 4,
    parameter int SETTLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_op,
    input  logic              stop_op,
    input  logic              stack_done,
    input  logic [ADDR_W-1:0] stack_addr,
    input  logic              mask_int,
    input  logic              mask_nmi,
    input  logic              stop_dis,
    input  logic              wdog_off,
    input  logic              spi_on,
    input  logic              sci_tx_on,
    input  logic              sci_rx_on,
    input  logic              ext_int_n,
    input  logic              ext_nmi_n,
    input  logic              ext_rst_n,
    input  logic              ext_int_pend,
    input  logic [N_INT-1:0]  int_req,
    output logic              cpu_clk_en,
    output logic              tmr_clk_en,
    output logic              spi_clk_en,
    output logic              sci_tx_clk_en,
    output logic              sci_rx_clk_en,
    output logic              osc_en,
    output logic              bus_rd_req,
    output logic [ADDR_W-1:0] bus_rd_addr,
    output logic              rst_route,
    output logic [2:0]        mode
);

    localparam int                CNT_W       = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);

    pm_state_e         state_q, state_nx;
    logic [CNT_W-1:0]  settle_q;
    logic [ADDR_W-1:0] addr_q;
    logic              route_q;
    logic [PIN_W-1:0]  pins_raw, pins_sync;
    logic              wait_wake, stop_wake_rst, stop_wake_int, stop_wake_raw;
    clk_en_t           en;

    assign pins_raw[PIN_INT] = ext_int_n;
    assign pins_raw[PIN_NMI] = ext_nmi_n;
    assign pins_raw[PIN_RST] = ext_rst_n;

    pm_pin_sync #(.W(PIN_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins_raw),
        .sync_o (pins_sync)
    );

    pm_wake_qual #(.N_INT(N_INT)) u_wake (
        .s_int_n       (pins_sync[PIN_INT]),
        .s_nmi_n       (pins_sync[PIN_NMI]),
        .s_rst_n       (pins_sync[PIN_RST]),
        .raw_int_n     (ext_int_n),
        .raw_nmi_n     (ext_nmi_n),
        .raw_rst_n     (ext_rst_n),
        .ext_int_pend  (ext_int_pend),
        .int_req       (int_req),
        .mask_int      (mask_int),
        .mask_nmi      (mask_nmi),
        .wait_wake     (wait_wake),
        .stop_wake_rst (stop_wake_rst),
        .stop_wake_int (stop_wake_int),
        .stop_wake_raw (stop_wake_raw)
    );

    pm_clk_gate u_gate (
        .state         (state_q),
        .mask_int      (mask_int),
        .wdog_off      (wdog_off),
        .spi_on        (spi_on),
        .sci_tx_on     (sci_tx_on),
        .sci_rx_on     (sci_rx_on),
        .stop_wake_raw (stop_wake_raw),
        .en            (en)
    );

    // Next-mode decision.
    always_comb begin
        state_nx = state_q;
        case (state_q)
            PM_RUN: begin
                if (wait_op)                   state_nx = PM_WAIT_STACK;
                else if (stop_op && !stop_dis) state_nx = PM_STOP;
            end
            PM_WAIT_STACK: if (stack_done) state_nx = PM_WAIT;
            PM_WAIT:       if (wait_wake)  state_nx = PM_RUN;
            PM_STOP: begin
                if (stop_wake_rst)      state_nx = PM_RUN;
                else if (stop_wake_int) state_nx = PM_STOP_RECOVER;
            end
            PM_STOP_RECOVER: if (settle_q == '0) state_nx = PM_RUN;
            default: state_nx = PM_RUN;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_nx;
    end

    // Oscillator settle counter, loaded on leaving stop through an interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            settle_q <= '0;
        else if (state_q == PM_STOP && state_nx == PM_STOP_RECOVER)
            settle_q <= SETTLE_LOAD;
        else if (state_q == PM_STOP_RECOVER && settle_q != '0)
            settle_q <= settle_q - CNT_W'(1);
    end

    // Capture the stacked condition-code address when stacking ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   addr_q <= '0;
        else if (state_q == PM_WAIT_STACK && stack_done) addr_q <= stack_addr;
    end

    // One-cycle routing pulse for a reset-pin exit from stop.
    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= 1'b0;
        else        route_q <= (state_q == PM_STOP) && stop_wake_rst;
    end

    assign cpu_clk_en    = en.cpu;
    assign tmr_clk_en    = en.tmr;
    assign spi_clk_en    = en.spi;
    assign sci_tx_clk_en = en.sci_tx;
    assign sci_rx_clk_en = en.sci_rx;
    assign osc_en        = en.osc;
    assign bus_rd_req    = (state_q == PM_WAIT);
    assign bus_rd_addr   = addr_q;
    assign rst_route     = route_q;
    assign mode          = state_q;

    // R2: end of stacking leads to wait with the sampled address.
    a_r2_stack_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_WAIT_STACK && stack_done) |=>
            (state_q == PM_WAIT && bus_rd_addr == $past(stack_addr)));

    // R3: the read address does not move while waiting.
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_WAIT && $past(state_q) == PM_WAIT) |-> $stable(bus_rd_addr));

    // R4: a qualified wake ends wait on the next edge.
    a_r4_wait_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_WAIT && wait_wake) |=> state_q == PM_RUN);

    // R5: timer keeps running unless both conditions hold.
    a_r5_tmr_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_WAIT && !(mask_int && wdog_off)) |-> tmr_clk_en);

    // R7: stop with stop disabled is a no-operation.
    a_r7_stop_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && stop_op && stop_dis && !wait_op) |=> state_q == PM_RUN);

    // R8: nothing but the oscillator may run in stop.
    a_r8_stop_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_STOP) |->
            (!cpu_clk_en && !tmr_clk_en && !spi_clk_en && !sci_tx_clk_en && !sci_rx_clk_en));

    // R9: the routing pulse only follows a stop.
    a_r9_rst_route: assert property (@(posedge clk) disable iff (!rst_n)
        rst_route |-> (state_q == PM_RUN && $past(state_q) == PM_STOP));

    // R10: recovery keeps the oscillator on and the CPU off.
    a_r10_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_STOP_RECOVER) |-> (osc_en && !cpu_clk_en));

endmodule

// File: tb/test_pm_power_ctrl.sv
`timescale 1ns/1ps
module test_pm_power_ctrl;

    localparam int AW  = 16;
    localparam int NI  = 4;
    localparam int SET = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wait_op, stop_op, stack_done;
    logic [AW-1:0] stack_addr;
    logic          mask_int, mask_nmi, stop_dis, wdog_off;
    logic          spi_on, sci_tx_on, sci_rx_on;
    logic          ext_int_n, ext_nmi_n, ext_rst_n, ext_int_pend;
    logic [NI-1:0] int_req;
    logic          cpu_clk_en, tmr_clk_en, spi_clk_en, sci_tx_clk_en, sci_rx_clk_en, osc_en;
    logic          bus_rd_req, rst_route;
    logic [AW-1:0] bus_rd_addr;
    logic [2:0]    mode;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 0;

    // Reference model state
    int            m_state;
    logic [2:0]    m_q[$];
    int            m_cnt;
    logic [AW-1:0] m_addr;
    bit            m_rr;

    pm_power_ctrl #(.ADDR_W(AW), .N_INT(NI), .SETTLE_CYC(SET)) i_pm_power_ctrl (
        .clk(clk), .rst_n(rst_n), .wait_op(wait_op), .stop_op(stop_op),
        .stack_done(stack_done), .stack_addr(stack_addr),
        .mask_int(mask_int), .mask_nmi(mask_nmi), .stop_dis(stop_dis), .wdog_off(wdog_off),
        .spi_on(spi_on), .sci_tx_on(sci_tx_on), .sci_rx_on(sci_rx_on),
        .ext_int_n(ext_int_n), .ext_nmi_n(ext_nmi_n), .ext_rst_n(ext_rst_n),
        .ext_int_pend(ext_int_pend), .int_req(int_req),
        .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en), .spi_clk_en(spi_clk_en),
        .sci_tx_clk_en(sci_tx_clk_en), .sci_rx_clk_en(sci_rx_clk_en), .osc_en(osc_en),
        .bus_rd_req(bus_rd_req), .bus_rd_addr(bus_rd_addr), .rst_route(rst_route), .mode(mode)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h", req, nm, act, exp);
        end
    endtask

    function automatic string mode_req(int s);
        case (s)
            0: return "R7";
            1: return "R2";
            2: return "R4";
            3: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Model update on each rising edge, from inputs driven at the last falling edge
    always @(posedge clk) begin
        logic [2:0] s;
        if (!rst_n) begin
            m_state = 0; m_q = {3'b111, 3'b111}; m_cnt = 0; m_addr = '0; m_rr = 0;
        end else begin
            s    = m_q[0];                       // {rst, nmi, int} after two flops
            m_rr = (m_state == 3) && !s[2];
            case (m_state)
                0: if (wait_op) m_state = 1; else if (stop_op && !stop_dis) m_state = 3;
                1: if (stack_done) begin m_state = 2; m_addr = stack_addr; end
                2: if (((!s[0] || int_req != 0) && !mask_int) || (!s[1] && !mask_nmi)) m_state = 0;
                3: if (!s[2]) m_state = 0;
                   else if (!s[0] || !s[1] || ext_int_pend) begin m_state = 4; m_cnt = SET - 1; end
                default: if (m_cnt == 0) m_state = 0; else m_cnt--;
            endcase
            m_q.push_back({ext_rst_n, ext_nmi_n, ext_int_n});
            void'(m_q.pop_front());
        end
    end

    // Compare every output shortly after each rising edge
    always @(posedge clk) begin
        #1.5;
        if (cmp_on) begin
            bit w, dark, raw;
            w    = (m_state == 2);
            dark = (m_state == 3) || (m_state == 4);
            raw  = !ext_int_n || !ext_nmi_n || !ext_rst_n || ext_int_pend;
            chk(mode_req(m_state), "mode", 32'(mode), 32'(m_state));
            chk("R2", "cpu_clk_en", 32'(cpu_clk_en), 32'(!(w || dark)));
            chk("R5", "tmr_clk_en", 32'(tmr_clk_en), dark ? 0 : (w ? 32'(!(mask_int && wdog_off)) : 1));
            chk("R6", "spi_clk_en", 32'(spi_clk_en), dark ? 0 : (w ? 32'(spi_on) : 1));
            chk("R6", "sci_tx_clk_en", 32'(sci_tx_clk_en), dark ? 0 : (w ? 32'(sci_tx_on) : 1));
            chk("R6", "sci_rx_clk_en", 32'(sci_rx_clk_en), dark ? 0 : (w ? 32'(sci_rx_on) : 1));
            chk("R8", "osc_en", 32'(osc_en), (m_state == 3) ? 32'(raw) : 1);
            chk("R3", "bus_rd_req", 32'(bus_rd_req), 32'(w));
            if (w) chk("R3", "bus_rd_addr", 32'(bus_rd_addr), 32'(m_addr));
            chk("R9", "rst_route", 32'(rst_route), 32'(m_rr));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter_wait(logic [AW-1:0] a);
        wait_op = 1; tick(1); wait_op = 0; tick(1);
        stack_addr = a; stack_done = 1; tick(1); stack_done = 0; stack_addr = 16'h1111; tick(1);
    endtask

    task automatic enter_stop();
        stop_dis = 0; stop_op = 1; tick(1); stop_op = 0;
        chk("R7", "mode after stop", 32'(mode), 3);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 0; wait_op = 0; stop_op = 0; stack_done = 0; stack_addr = 16'h01F3;
        mask_int = 1; mask_nmi = 0; stop_dis = 1; wdog_off = 0;
        spi_on = 1; sci_tx_on = 1; sci_rx_on = 1;
        ext_int_n = 1; ext_nmi_n = 1; ext_rst_n = 1; ext_int_pend = 0; int_req = '0;
        tick(3);
        // R1: reset state
        chk("R1", "mode", 32'(mode), 0);
        chk("R1", "cpu_clk_en", 32'(cpu_clk_en), 1);
        chk("R1", "osc_en", 32'(osc_en), 1);
        chk("R1", "bus_rd_req", 32'(bus_rd_req), 0);
        chk("R1", "rst_route", 32'(rst_route), 0);
        rst_n = 1; cmp_on = 1; tick(2);

        // Wait with masked sources, peripheral gating varied live (R2 R3 R5 R6)
        wdog_off = 1; spi_on = 0; sci_rx_on = 0;
        enter_wait(16'h0A5C);
        chk("R2", "mode in wait", 32'(mode), 2);
        chk("R3", "bus_rd_addr", 32'(bus_rd_addr), 32'h0A5C);
        chk("R5", "tmr gated", 32'(tmr_clk_en), 0);
        tick(2); spi_on = 1; tick(1); wdog_off = 0; tick(1); sci_tx_on = 0; sci_rx_on = 1; tick(1);
        int_req = 4'b0010; tick(4);
        chk("R4", "masked internal no wake", 32'(mode), 2);
        ext_int_n = 0; tick(4);
        chk("R4", "masked pin no wake", 32'(mode), 2);
        ext_nmi_n = 0; tick(3);
        chk("R4", "nmi wake", 32'(mode), 0);
        ext_nmi_n = 1; ext_int_n = 1; int_req = '0; sci_tx_on = 1; tick(3);

        // Wake from internal request with mask clear (R4)
        mask_int = 0;
        enter_wait(16'h7FFE);
        int_req = 4'b1000; tick(1); int_req = '0; tick(1);
        chk("R4", "internal wake", 32'(mode), 0);

        // Masked nmi ignored, pin interrupt wakes after sync (R4)
        mask_nmi = 1;
        enter_wait(16'h0200);
        ext_nmi_n = 0; tick(4);
        chk("R4", "masked nmi no wake", 32'(mode), 2);
        ext_int_n = 0; tick(3);
        chk("R4", "pin wake", 32'(mode), 0);
        ext_int_n = 1; ext_nmi_n = 1; mask_nmi = 0; tick(3);

        // Stop disabled: no-operation (R7)
        stop_dis = 1; stop_op = 1; tick(1); stop_op = 0; tick(1);
        chk("R7", "stop nop mode", 32'(mode), 0);
        chk("R7", "stop nop cpu", 32'(cpu_clk_en), 1);

        // Stop, raw pin restarts oscillator, recovery length (R8 R10)
        enter_stop(); tick(3);
        chk("R8", "osc off in stop", 32'(osc_en), 0);
        ext_int_n = 0; #0.5;
        chk("R8", "osc async on", 32'(osc_en), 1);
        begin
            int rec = 0;
            for (int k = 0; k < 40; k++) begin
                tick(1);
                if (mode == 3'd4) rec++;
                if (mode == 3'd0 && rec > 0) break;
            end
            chk("R10", "recovery cycles", 32'(rec), SET);
        end
        ext_int_n = 1; tick(3);

        // Stop left through a latched edge interrupt (R10)
        enter_stop(); tick(2);
        ext_int_pend = 1; tick(1); ext_int_pend = 0;
        chk("R10", "pending enters recovery", 32'(mode), 4);
        tick(SET + 2);

        // Reset and interrupt pins fall together in stop (R9)
        enter_stop(); tick(2);
        ext_rst_n = 0; ext_int_n = 0;
        begin
            bit seen = 0;
            bit rec  = 0;
            for (int k = 0; k < 6; k++) begin
                tick(1);
                if (mode == 3'd4) rec = 1;
                if (rst_route) begin seen = 1; chk("R9", "mode at route", 32'(mode), 0); end
            end
            chk("R9", "route pulse seen", 32'(seen), 1);
            chk("R9", "no recovery", 32'(rec), 0);
        end
        ext_rst_n = 1; ext_int_n = 1; tick(3);

        // Wait and stop strobes together (R2)
        stop_dis = 0; wait_op = 1; stop_op = 1; tick(1); wait_op = 0; stop_op = 0;
        chk("R2", "wait wins", 32'(mode), 1);
        stack_done = 1; tick(1); stack_done = 0;
        int_req = 4'b0001; tick(2); int_req = '0; tick(2);

        cmp_on = 0;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule